// File: doc/BRIEF.md
# Window and Timeout Watchdog Supervisor

This block supervises a host processor by expecting periodic service writes. Every write to its control register counts as a service event and restarts a period timer that advances on a millisecond tick. The block runs in one of three modes. In window mode a service write must not come too early or too late. In timeout mode a late service first raises a cyclic interrupt and escalates to a reset only if that interrupt is still pending at the next expiry. In off mode the timer does not run.

The mode depends on an external disable pin, a mode bit held in the control register, the host operating state (Normal or Standby) and whether an interrupt is pending. Any violation produces a single-cycle system reset request. A watchdog-caused reset clears the interrupt flag and the timer, and reloads the default period code.

Top module: `wdog_supervisor`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `sys_rst_req`=0, `ci_flag`=0, `period_sel`=3'b100 and `mode_bit_q`=0. The `wd_mode` encoding is OFF=2'd0, WINDOW=2'd1, TIMEOUT=2'd2.
- R2: `wd_mode` is OFF when `wd_off_pin`=1. It is also OFF when `host_standby`=1, `mode_bit_q`=1 and no interrupt is pending, where pending means `ci_flag`|`ext_irq`. Otherwise it is WINDOW when `host_standby`=0 and `mode_bit_q`=0, and TIMEOUT in every remaining case.
- R3: Period codes 0..7 select 8, 16, 32, 64, 128, 256, 1024 and 4096 ticks. The count rises by one on each `tick` cycle that has no write. The tick that would bring the count up to the period is the expiry. The window boundary is half the period.
- R4: In WINDOW mode, a write while the count is below half the period requests a reset. A write at or above half restarts the count with no reset. The write's `wr_period` is stored unless a reset is requested.
- R5: In WINDOW mode, an expiry requests a reset.
- R6: In TIMEOUT mode, any write restarts the count. An expiry with `ci_flag`=0 sets `ci_flag` and restarts the count. An expiry with `ci_flag`=1 requests a reset.
- R7: A write with `wr_ci_clr`=1 clears `ci_flag`.
- R8: A change of `wd_off_pin` level requests a reset. While the pin is high, no expiry and no interrupt occur.
- R9: In Standby with `mode_bit_q`=1 the watchdog is off. A pending interrupt from `ext_irq` or `ci_flag` puts it into TIMEOUT mode.
- R10: In Standby, a write that would change the mode bit while an interrupt is pending leaves `mode_bit_q` unchanged and requests no reset. The other fields of the write still take effect.
- R11: In Normal state, a write that changes the mode bit stores the new bit and requests a reset.
- R12: `sys_rst_req` is registered. On the same edge it rises, `ci_flag` goes to 0, the count goes to 0 and `period_sel` goes to 3'b100, even if a written period arrived in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle millisecond tick |
| wd_off_pin | input | 1 | External watchdog disable level |
| host_standby | input | 1 | Host state: 0 Normal, 1 Standby |
| ext_irq | input | 1 | Other interrupt pending in the host |
| wr_en | input | 1 | Control register write strobe (service event) |
| wr_period | input | 3 | Period code written |
| wr_mode_bit | input | 1 | Mode bit written |
| wr_ci_clr | input | 1 | Write 1 to clear the cyclic interrupt flag |
| sys_rst_req | output | 1 | One-cycle system reset request |
| ci_flag | output | 1 | Cyclic interrupt pending |
| wd_mode | output | 2 | Current mode (OFF/WINDOW/TIMEOUT) |
| period_sel | output | 3 | Stored period code |
| mode_bit_q | output | 1 | Stored mode bit |

## Verification
A wrong count shows up as a reset request or an interrupt that comes one tick early or late at an expiry, or as an early or late boundary between the closed and open halves of the window. A period of 8 ticks exposes this within about ten cycles. A corrupted mode bit or interrupt flag changes `wd_mode` in the very cycle after the faulty edge, and a missed clear shows up at the next edge as a `ci_flag` or `period_sel` that survives a reset request. The bench compares every output against a cycle-accurate reference model on every cycle, so any divergence is reported on the edge where it first appears.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic [1:0] {
        WD_OFF     = 2'd0,
        WD_WINDOW  = 2'd1,
        WD_TIMEOUT = 2'd2
    } wd_mode_e;

    localparam logic [2:0] PERIOD_DEFAULT = 3'b100;

    typedef struct packed {
        logic       en;
        logic [2:0] period;
        logic       mode_bit;
        logic       ci_clr;
    } wr_req_t;

    // ticks per period code: doubling for codes 0..5, then two wider steps
    function automatic int unsigned period_ticks(input logic [2:0] code,
                                                 input int unsigned base);
        case (code)
            3'd6:    return base << 7;
            3'd7:    return base << 9;
            default: return base << code;
        endcase
    endfunction

    function automatic wd_mode_e decode_mode(input logic pin_off,
                                             input logic standby,
                                             input logic mode_bit,
                                             input logic irq_pend);
        if (pin_off)
            return WD_OFF;
        if (standby && mode_bit && !irq_pend)
            return WD_OFF;
        if (!standby && !mode_bit)
            return WD_WINDOW;
        return WD_TIMEOUT;
    endfunction

endpackage

// File: rtl/wdog_mode_sel.sv
module wdog_mode_sel
    import wdog_pkg::*;
(
    input  logic     pin_off,
    input  logic     standby,
    input  logic     mode_bit,
    input  logic     irq_pend,
    output wd_mode_e mode
);
    always_comb mode = decode_mode(pin_off, standby, mode_bit, irq_pend);
endmodule

// File: rtl/wdog_period_timer.sv
module wdog_period_timer
    import wdog_pkg::*;
#(
    parameter int unsigned BASE_TICKS = 8,
    parameter int unsigned CNT_W      = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       period,
    input  logic             restart,
    input  logic             clear,
    input  logic             tick_en,
    output logic [CNT_W-1:0] cnt,
    output logic             at_last,
    output logic             in_closed
);
    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] half;

    always_comb begin
        limit     = CNT_W'(period_ticks(period, BASE_TICKS));
        half      = limit >> 1;
        at_last   = (cnt == limit - CNT_W'(1));
        in_closed = (cnt < half);
    end

    always_ff @(posedge clk) begin
        if (rst || clear)
            cnt <= '0;
        else if (restart)
            cnt <= '0;
        else if (tick_en)
            cnt <= at_last ? '0 : cnt + CNT_W'(1);
    end
endmodule

// File: rtl/wdog_event_core.sv
module wdog_event_core
    import wdog_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  wr_req_t    wr,
    input  logic       pin_off,
    input  logic       standby,
    input  logic       ext_irq,
    input  wd_mode_e   mode,
    input  logic       tick,
    input  logic       at_last,
    input  logic       in_closed,
    output logic       fire,
    output logic       irq_pend,
    output logic       rst_req_q,
    output logic       ci_q,
    output logic [2:0] period_q,
    output logic       mode_bit_q
);
    logic pin_prev_q;
    logic pin_evt, bit_chg, bit_accept, bit_rst;
    logic closed_hit, expiry, win_expiry, to_expiry, to_escalate;

    always_comb begin
        irq_pend    = ci_q | ext_irq;
        pin_evt     = (pin_off != pin_prev_q);
        bit_chg     = wr.en && (wr.mode_bit != mode_bit_q);
        bit_accept  = bit_chg && !(standby && irq_pend);
        bit_rst     = bit_chg && !standby;
        closed_hit  = wr.en && (mode == WD_WINDOW) && in_closed;
        expiry      = !wr.en && tick && (mode != WD_OFF) && at_last;
        win_expiry  = expiry && (mode == WD_WINDOW);
        to_expiry   = expiry && (mode == WD_TIMEOUT);
        to_escalate = to_expiry && ci_q;
        fire        = pin_evt | bit_rst | closed_hit | win_expiry | to_escalate;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rst_req_q  <= 1'b0;
            ci_q       <= 1'b0;
            period_q   <= PERIOD_DEFAULT;
            mode_bit_q <= 1'b0;
            pin_prev_q <= pin_off;
        end else begin
            rst_req_q  <= fire;
            pin_prev_q <= pin_off;
            if (bit_accept)
                mode_bit_q <= wr.mode_bit;
            if (fire) begin
                ci_q     <= 1'b0;
                period_q <= PERIOD_DEFAULT;
            end else begin
                if (wr.en)
                    period_q <= wr.period;
                if (to_expiry)
                    ci_q <= 1'b1;
                else if (wr.en && wr.ci_clr)
                    ci_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/wdog_supervisor.sv
module wdog_supervisor
    import wdog_pkg::*;
#(
    parameter int unsigned BASE_TICKS = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       wd_off_pin,
    input  logic       host_standby,
    input  logic       ext_irq,
    input  logic       wr_en,
    input  logic [2:0] wr_period,
    input  logic       wr_mode_bit,
    input  logic       wr_ci_clr,
    output logic       sys_rst_req,
    output logic       ci_flag,
    output logic [1:0] wd_mode,
    output logic [2:0] period_sel,
    output logic       mode_bit_q
);
    localparam int unsigned CNT_W = $clog2(BASE_TICKS * 512) + 1;

    wr_req_t          wr;
    wd_mode_e         mode;
    logic             fire, irq_pend, at_last, in_closed;
    logic             ci_q, bit_q;
    logic [2:0]       per_q;
    logic [CNT_W-1:0] cnt_w;

    always_comb begin
        wr.en       = wr_en;
        wr.period   = wr_period;
        wr.mode_bit = wr_mode_bit;
        wr.ci_clr   = wr_ci_clr;
    end

    wdog_mode_sel u_mode (
        .pin_off (wd_off_pin),
        .standby (host_standby),
        .mode_bit(bit_q),
        .irq_pend(irq_pend),
        .mode    (mode)
    );

    wdog_period_timer #(.BASE_TICKS(BASE_TICKS), .CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .period   (per_q),
        .restart  (wr_en && (mode != WD_OFF)),
        .clear    (fire || (mode == WD_OFF)),
        .tick_en  (tick && !wr_en && (mode != WD_OFF)),
        .cnt      (cnt_w),
        .at_last  (at_last),
        .in_closed(in_closed)
    );

    wdog_event_core u_core (
        .clk       (clk),
        .rst       (rst),
        .wr        (wr),
        .pin_off   (wd_off_pin),
        .standby   (host_standby),
        .ext_irq   (ext_irq),
        .mode      (mode),
        .tick      (tick),
        .at_last   (at_last),
        .in_closed (in_closed),
        .fire      (fire),
        .irq_pend  (irq_pend),
        .rst_req_q (sys_rst_req),
        .ci_q      (ci_q),
        .period_q  (per_q),
        .mode_bit_q(bit_q)
    );

    assign ci_flag    = ci_q;
    assign period_sel = per_q;
    assign mode_bit_q = bit_q;
    assign wd_mode    = mode;
endmodule

// File: rtl/wdog_supervisor_chk.sv
module wdog_supervisor_chk
    import wdog_pkg::*;
#(
    parameter int unsigned BASE_TICKS = 8,
    parameter int unsigned CNT_W      = 13
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic             host_standby,
    input logic             ext_irq,
    input logic             sys_rst_req,
    input logic             ci_flag,
    input logic [1:0]       wd_mode,
    input logic [2:0]       period_sel,
    input logic             mode_bit_q,
    input logic [CNT_W-1:0] cnt
);
    logic [CNT_W-1:0] lim;
    assign lim = CNT_W'(period_ticks(period_sel, BASE_TICKS));

    // R12
    rst_req_clears_chk: assert property (@(posedge clk) disable iff (rst)
        sys_rst_req |-> (!ci_flag && period_sel == PERIOD_DEFAULT && cnt == '0));

    // R3
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt < lim);

    // R4
    closed_window_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wd_mode == 2'd1 && cnt < (lim >> 1)) |=> sys_rst_req);

    // R6
    ci_from_timeout_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ci_flag) |-> ($past(wd_mode) == 2'd2 && !sys_rst_req));

    // R8
    off_holds_timer_chk: assert property (@(posedge clk) disable iff (rst)
        (wd_mode == 2'd0) |=> (cnt == '0));

    // R10
    standby_bit_locked_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && host_standby && (ci_flag || ext_irq)) |=> $stable(mode_bit_q));
endmodule

bind wdog_supervisor wdog_supervisor_chk #(.BASE_TICKS(BASE_TICKS), .CNT_W(CNT_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .host_standby(host_standby),
    .ext_irq     (ext_irq),
    .sys_rst_req (sys_rst_req),
    .ci_flag     (ci_flag),
    .wd_mode     (wd_mode),
    .period_sel  (period_sel),
    .mode_bit_q  (mode_bit_q),
    .cnt         (cnt_w)
);

// File: tb/wdog_supervisor_tb.sv
module wdog_supervisor_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0, pin = 1'b0, stby = 1'b0, ext = 1'b0;
    logic       wr_en = 1'b0, wr_bit = 1'b0, wr_clr = 1'b0;
    logic [2:0] wr_per = 3'd0;
    logic       sys_rst_req, ci_flag, mode_bit_q;
    logic [1:0] wd_mode;
    logic [2:0] period_sel;

    int checks = 0;
    int bad    = 0;

    // reference model state
    int         m_cnt;
    logic       m_ci, m_bit, m_prev, m_rst;
    logic [2:0] m_per;

    always #2 clk = ~clk;

    wdog_supervisor dut_i (
        .clk(clk), .rst(rst), .tick(tick), .wd_off_pin(pin), .host_standby(stby),
        .ext_irq(ext), .wr_en(wr_en), .wr_period(wr_per), .wr_mode_bit(wr_bit),
        .wr_ci_clr(wr_clr), .sys_rst_req(sys_rst_req), .ci_flag(ci_flag),
        .wd_mode(wd_mode), .period_sel(period_sel), .mode_bit_q(mode_bit_q)
    );

    function automatic int ticks_of(input logic [2:0] c);
        case (c)
            3'd0: return 8;    3'd1: return 16;   3'd2: return 32;  3'd3: return 64;
            3'd4: return 128;  3'd5: return 256;  3'd6: return 1024;
            default: return 4096;
        endcase
    endfunction

    function automatic logic [1:0] exp_mode();
        if (pin) return 2'd0;
        if (stby && m_bit && !(m_ci || ext)) return 2'd0;
        if (!stby && !m_bit) return 2'd1;
        return 2'd2;
    endfunction

    task automatic model_reset();
        m_cnt = 0; m_ci = 0; m_bit = 0; m_per = 3'b100; m_rst = 0; m_prev = pin;
    endtask

    task automatic model_step();
        logic [1:0] md;
        logic       fire, pend, nci, nbit;
        logic [2:0] nper;
        int         lim, ncnt;
        md   = exp_mode();
        pend = m_ci || ext;
        lim  = ticks_of(m_per);
        fire = (pin != m_prev);
        ncnt = m_cnt; nci = m_ci; nper = m_per; nbit = m_bit;
        if (wr_en) begin
            nper = wr_per;
            if (wr_clr) nci = 0;
            if (wr_bit != m_bit) begin
                if (!stby) begin nbit = wr_bit; fire = 1; end
                else if (!pend) nbit = wr_bit;
            end
            if (md == 2'd1 && m_cnt < lim / 2) fire = 1;
            ncnt = 0;
        end else if (tick && md != 2'd0) begin
            if (m_cnt == lim - 1) begin
                if (md == 2'd1) fire = 1;
                else if (m_ci) fire = 1;
                else begin nci = 1; ncnt = 0; end
            end else ncnt = m_cnt + 1;
        end
        if (md == 2'd0) ncnt = 0;
        if (fire) begin ncnt = 0; nci = 0; nper = 3'b100; end
        m_cnt = ncnt; m_ci = nci; m_per = nper; m_bit = nbit;
        m_prev = pin; m_rst = fire;
    endtask

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cmp_all(input string tag);
        check(tag, {sys_rst_req, ci_flag, period_sel, mode_bit_q, wd_mode},
                   {m_rst, m_ci, m_per, m_bit, exp_mode()});
    endtask

    task automatic step(input string tag);
        model_step();
        @(posedge clk);
        @(negedge clk);
        cmp_all(tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(tag);
    endtask

    task automatic wr(input logic [2:0] p, input logic b, input logic c, input string tag);
        wr_en = 1; wr_per = p; wr_bit = b; wr_clr = c;
        step(tag);
        wr_en = 0; wr_clr = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        @(negedge clk);
        model_reset();
        repeat (3) @(negedge clk);
        // R1 reset values and mode encoding
        check("R1 rst_req", sys_rst_req, 0);
        check("R1 period", period_sel, 3'b100);
        check("R2 window mode", wd_mode, 2'd1);
        rst = 0; tick = 1;

        // R4 closed-window write, R12 period reload overrides write
        wr(3'd0, 0, 0, "R4");
        check("R4 closed trigger", sys_rst_req, 1);
        check("R12 period reload", period_sel, 3'b100);
        step("R12");
        check("R12 single pulse", sys_rst_req, 0);

        // R3 boundary at half of 128, then of 8
        idle(63, "R3");
        wr(3'd0, 0, 0, "R3");
        check("R3 open at half", sys_rst_req, 0);
        check("R4 period stored", period_sel, 3'd0);
        idle(3, "R3");
        wr(3'd0, 0, 0, "R3");
        check("R3 closed below half", sys_rst_req, 1);
        idle(64, "R4");
        wr(3'd0, 0, 0, "R4");
        idle(4, "R4");
        wr(3'd0, 0, 0, "R4");
        check("R4 open restart", sys_rst_req, 0);
        // R5 expiry after exactly 8 ticks
        idle(7, "R5");
        check("R5 before expiry", sys_rst_req, 0);
        step("R5");
        check("R5 window expiry", sys_rst_req, 1);

        // R11 mode-bit change in Normal
        wr(3'd0, 1, 0, "R11");
        check("R11 reset on bit change", sys_rst_req, 1);
        check("R11 bit stored", mode_bit_q, 1);
        check("R2 timeout mode", wd_mode, 2'd2);
        // R6 timeout escalation
        wr(3'd0, 1, 0, "R6");
        check("R6 early write ok", sys_rst_req, 0);
        idle(7, "R6");
        check("R6 no ci yet", ci_flag, 0);
        step("R6");
        check("R6 ci set", ci_flag, 1);
        idle(7, "R6");
        step("R6");
        check("R6 escalation", sys_rst_req, 1);
        check("R12 ci cleared", ci_flag, 0);
        // R7 write-one-to-clear
        wr(3'd0, 1, 0, "R7");
        idle(8, "R7");
        check("R7 ci pending", ci_flag, 1);
        wr(3'd0, 1, 1, "R7");
        check("R7 ci cleared", ci_flag, 0);

        // R9 standby off and re-enable
        stby = 1;
        step("R9");
        check("R9 off", wd_mode, 2'd0);
        idle(300, "R9");
        check("R9 no ci while off", ci_flag, 0);
        ext = 1;
        step("R9");
        check("R9 re-enabled", wd_mode, 2'd2);
        // R10 locked bit with pending interrupt
        wr(3'd1, 0, 0, "R10");
        check("R10 bit kept", mode_bit_q, 1);
        check("R10 no reset", sys_rst_req, 0);
        check("R10 period applied", period_sel, 3'd1);
        ext = 0;
        wr(3'd1, 0, 0, "R10");
        check("R10 accepted w/o pending", mode_bit_q, 0);

        // R8 pin edges
        pin = 1;
        step("R8");
        check("R8 rise reset", sys_rst_req, 1);
        check("R8 off", wd_mode, 2'd0);
        idle(50, "R8");
        check("R8 quiet", sys_rst_req | ci_flag, 0);
        pin = 0;
        step("R8");
        check("R8 fall reset", sys_rst_req, 1);

        // random phase against the model
        for (int i = 0; i < 6000; i++) begin
            tick   = ($urandom % 2) == 0;
            wr_en  = ($urandom % 25) == 0;
            wr_per = 3'($urandom % 3);
            wr_bit = (($urandom % 6) == 0) ? ~m_bit : m_bit;
            wr_clr = ($urandom % 3) == 0;
            if (($urandom % 700) == 0) pin = ~pin;
            if (($urandom % 300) == 0) stby = ~stby;
            if (($urandom % 90) == 0) ext = ~ext;
            step("R2 R6 R9 random");
        end
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule